// File: doc/BRIEF.md
# Fine-Grain Pipelined Three-Tap FIR Filter

This block is a three-tap finite impulse response filter that computes y(n) = a·x(n) + b·x(n−1) + c·x(n−2) on a stream of signed samples, one sample per clock when the stream flows freely. Each coefficient multiply is split into two register-separated halves. The first half forms two partial products, one from the low half and one from the high half of the sample. The second half shifts the high partial product up by half the sample width and adds the two. A third register layer holds the three-term sum. All registers sit on forward-only cuts, so the longest path is about half a multiply rather than a multiply plus two adds. The cost is a latency of three accepted-to-visible cycles.

Samples arrive on a valid/ready stream and results leave on a valid/ready stream. Back-pressure is global. `in_ready` follows `out_ready` (and is low in reset). When `out_ready` is low, every pipeline register and the tap history hold, and the block accepts no sample. A cycle with `in_valid` low sends a bubble down the pipeline and leaves the tap history unchanged. The three coefficients are plain inputs and are meant to stay static while a stream runs. A coefficient value takes effect for samples accepted while it is applied. The result is full precision, 2·W+2 bits wide, with no rounding or saturation.

Top module: `fir3_fine_pipe`

## Requirements
- R1: For each accepted sample x(n), the block emits exactly one result equal to a·x(n) + b·x(n−1) + c·x(n−2), where x(n−1) and x(n−2) are the two previously accepted samples. Results leave in acceptance order.
- R2: After reset, missing history taps count as zero. The first result is a·x(0) and the second is a·x(1)+b·x(0).
- R3: Each product is exact for every pair of signed W-bit operands, including the patterns where the low half of the sample is all ones or zero and the high half is the most negative value.
- R4: `out_data` is a signed 2·W+2-bit two's-complement value and never wraps, even with every sample and coefficient at −2^(W−1). That case gives 3·2^(2W−2).
- R5: With `out_ready` held high, a sample accepted at clock edge k appears with `out_valid` high after edge k+2. It is therefore visible in the cycle that edge k+3 samples.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold unchanged and `in_ready` is low. A sample offered while `in_ready` is low is not taken and does not enter the history.
- R7: A cycle with `in_valid` low produces no result and does not shift the tap history.
- R8: A synchronous reset (`rst` high at a rising edge) clears the history, all pipeline stages and `out_valid`. While `rst` is high, `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| coef_a | input | W | Signed coefficient applied to x(n) |
| coef_b | input | W | Signed coefficient applied to x(n−1) |
| coef_c | input | W | Signed coefficient applied to x(n−2) |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block takes the sample at this edge; equals out_ready when not in reset |
| in_data | input | W | Signed input sample |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result; low stalls the whole pipeline |
| out_data | output | 2·W+2 | Signed full-precision filter result |

## Verification
A wrong partial-product split or a bad shift shows up as a wrong `out_data` three advancing cycles after the offending sample. It reaches the ports only for operands that exercise the faulty half, so sample patterns with extreme high and low halves are mixed into the random stream. A history fault, such as shifting on a bubble or on a refused sample, corrupts the next two results and not the current one. A lost or duplicated valid bit shows as a result count that no longer matches the accepted count. A stall fault shows in the very next cycle as a changed `out_data` or a dropped `out_valid`.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
  localparam int NTAPS   = 3;
  localparam int LATENCY = 3;

  function automatic int prod_width(input int w);
    return 2 * w;
  endfunction

  function automatic int sum_width(input int w);
    return 2 * w + 2;
  endfunction
endpackage

// File: rtl/fir3_split_mul.sv
module fir3_split_mul #(
  parameter int W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [W-1:0]     coef,
  input  logic signed [W-1:0]     sample,
  output logic signed [2*W-1:0]   prod
);
  localparam int LO_W  = W / 2;
  localparam int HI_W  = W - LO_W;
  localparam int PLO_W = W + LO_W + 1;
  localparam int PHI_W = W + HI_W;
  localparam int P_W   = 2 * W;

  logic signed [LO_W:0]    lo_s;
  logic signed [HI_W-1:0]  hi_s;
  logic signed [PLO_W-1:0] plo_q;
  logic signed [PHI_W-1:0] phi_q;
  logic signed [P_W-1:0]   prod_q;

  assign lo_s = signed'({1'b0, sample[LO_W-1:0]});
  assign hi_s = sample[W-1:LO_W];

  // first half: partial products
  always_ff @(posedge clk) begin
    if (rst) begin
      plo_q <= '0;
      phi_q <= '0;
    end else if (en) begin
      plo_q <= PLO_W'(coef) * PLO_W'(lo_s);
      phi_q <= PHI_W'(coef) * PHI_W'(hi_s);
    end
  end

  // second half: align and combine
  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
    end else if (en) begin
      prod_q <= (P_W'(phi_q) <<< LO_W) + P_W'(plo_q);
    end
  end

  assign prod = prod_q;

  // shadow of the operands held by the first half, for checking only
  logic signed [W-1:0] sh_c, sh_x;
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_c <= '0;
      sh_x <= '0;
    end else if (en) begin
      sh_c <= coef;
      sh_x <= sample;
    end
  end

  a_r3_split_exact: assert property (@(posedge clk) disable iff (rst)
    en |=> (prod == P_W'($past(sh_c)) * P_W'($past(sh_x))));
endmodule

// File: rtl/fir3_delay_line.sv
module fir3_delay_line #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic [W-1:0] hist [DEPTH]
);
  logic [W-1:0] line_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
    end else if (shift) begin
      line_q[0] <= din;
      for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
    end
  end

  assign hist = line_q;

  a_r7_hold_history: assert property (@(posedge clk) disable iff (rst)
    !shift |=> (line_q[0] == $past(line_q[0])));
endmodule

// File: rtl/fir3_valid_pipe.sv
module fir3_valid_pipe #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic vin,
  output logic vout
);
  logic [STAGES-1:0] v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
    end else if (en) begin
      v_q <= {v_q[STAGES-2:0], vin};
    end
  end

  assign vout = v_q[STAGES-1];
endmodule

// File: rtl/fir3_sum_stage.sv
module fir3_sum_stage #(
  parameter int P_W = 32,
  parameter int N   = 3,
  parameter int O_W = 34
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic signed [P_W-1:0] terms [N],
  output logic signed [O_W-1:0] sum
);
  logic signed [O_W-1:0] acc;
  logic signed [O_W-1:0] sum_q;

  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++) acc = acc + O_W'(terms[i]);
  end

  always_ff @(posedge clk) begin
    if (rst)     sum_q <= '0;
    else if (en) sum_q <= acc;
  end

  assign sum = sum_q;
endmodule

// File: rtl/fir3_fine_pipe.sv
module fir3_fine_pipe
  import fir3_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic signed [W-1:0]             coef_a,
  input  logic signed [W-1:0]             coef_b,
  input  logic signed [W-1:0]             coef_c,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic signed [W-1:0]             in_data,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic signed [2*W+1:0]           out_data
);
  localparam int P_W   = prod_width(W);
  localparam int O_W   = sum_width(W);
  localparam int DEPTH = NTAPS - 1;

  logic advance, accept;
  logic [W-1:0]          hist [DEPTH];
  logic signed [W-1:0]   tap  [NTAPS];
  logic signed [W-1:0]   coef [NTAPS];
  logic signed [P_W-1:0] prod [NTAPS];

  assign advance  = out_ready && !rst;
  assign in_ready = advance;
  assign accept   = in_valid && advance;

  assign coef[0] = coef_a;
  assign coef[1] = coef_b;
  assign coef[2] = coef_c;

  fir3_delay_line #(.W(W), .DEPTH(DEPTH)) hist_i (
    .clk(clk), .rst(rst), .shift(accept), .din(in_data), .hist(hist)
  );

  assign tap[0] = in_data;
  for (genvar t = 1; t < NTAPS; t++) begin : g_tap
    assign tap[t] = signed'(hist[t-1]);
  end

  for (genvar t = 0; t < NTAPS; t++) begin : g_mul
    fir3_split_mul #(.W(W)) mul_i (
      .clk(clk), .rst(rst), .en(advance),
      .coef(coef[t]), .sample(tap[t]), .prod(prod[t])
    );
  end

  fir3_sum_stage #(.P_W(P_W), .N(NTAPS), .O_W(O_W)) sum_i (
    .clk(clk), .rst(rst), .en(advance), .terms(prod), .sum(out_data)
  );

  fir3_valid_pipe #(.STAGES(LATENCY)) vld_i (
    .clk(clk), .rst(rst), .en(advance), .vin(accept), .vout(out_valid)
  );

  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> !out_valid);

  a_r6_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    ($past(accept, 3) && $past(advance, 2) && $past(advance, 1)) |-> out_valid);

  a_r8_no_take_in_reset: assert property (@(posedge clk)
    rst |-> !in_ready);
endmodule

// File: tb/fir3_fine_pipe_tb_top.sv
`timescale 1ns/1ps
module fir3_fine_pipe_tb_top;
  localparam int W  = 16;
  localparam int OW = 2 * W + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [W-1:0]  coef_a = '0, coef_b = '0, coef_c = '0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic signed [W-1:0]  in_data = '0;
  logic                 out_valid;
  logic                 out_ready = 1'b0;
  logic signed [OW-1:0] out_data;

  always #4 clk = ~clk;

  fir3_fine_pipe #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  longint h1 = 0, h2 = 0;
  longint exp_q [$];
  bit     prev_stall = 0;
  longint prev_data  = 0;
  string  cur_req = "R1";

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint model_y(input longint x, input longint p1, input longint p2);
    return longint'(coef_a) * x + longint'(coef_b) * p1 + longint'(coef_c) * p2;
  endfunction

  task automatic cycle(input bit iv, input logic signed [W-1:0] id, input bit ordy);
    longint act, e;
    @(negedge clk);
    in_valid  = iv;
    in_data   = id;
    out_ready = ordy;
    #1;
    if (prev_stall) begin
      act = out_data;
      check(out_valid && act == prev_data, "R6", act, prev_data);
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(model_y(longint'(in_data), h1, h2));
      h2 = h1;
      h1 = longint'(in_data);
    end
    if (out_valid && out_ready) begin
      act = out_data;
      if (exp_q.size() == 0) begin
        check(1'b0, cur_req, act, 0);
      end else begin
        e = exp_q.pop_front();
        check(act == e, cur_req, act, e);
      end
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    #1;
    check(!in_ready, "R8", in_ready, 0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(!out_valid, "R8", out_valid, 0);
    exp_q.delete();
    h1 = 0; h2 = 0;
    prev_stall = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) cycle(1'b0, '0, 1'b1);
    check(exp_q.size() == 0, cur_req, exp_q.size(), 0);
  endtask

  initial begin
    int found;
    void'($urandom(32'h5eed_f17e));
    coef_a = 16'sd3; coef_b = -16'sd5; coef_c = 16'sd7;
    do_reset();

    // R2: history starts at zero
    cur_req = "R2";
    cycle(1, 16'sd100, 1);
    cycle(1, 16'sd10, 1);
    cycle(1, -16'sd1, 1);
    drain();

    // R5: latency with out_ready high
    do_reset();
    cur_req = "R5";
    cycle(1, 16'sd9, 1);
    found = 0;
    for (int k = 1; k <= 6; k++) begin
      cycle(0, '0, 1);
      if (out_valid && found == 0) found = k;
    end
    check(found == 3, "R5", found, 3);
    check(exp_q.size() == 0, "R5", exp_q.size(), 0);

    // R3: extreme half patterns through the split multiply
    do_reset();
    coef_a = -16'sd32768; coef_b = 16'sd32767; coef_c = -16'sd1;
    cur_req = "R3";
    cycle(1, -16'sd32768, 1);
    cycle(1, 16'sh00FF, 1);
    cycle(1, 16'sh7FFF, 1);
    cycle(1, 16'shFF00, 1);
    cycle(1, 16'sh80FF, 1);
    cycle(1, 16'sd1, 1);
    drain();

    // R4: all operands most negative
    do_reset();
    coef_a = -16'sd32768; coef_b = -16'sd32768; coef_c = -16'sd32768;
    cur_req = "R4";
    for (int i = 0; i < 4; i++) cycle(1, -16'sd32768, 1);
    drain();
    begin
      longint mx = 3 * (64'sd1 <<< (2*W-2));
      check(model_y(-32768, -32768, -32768) == mx, "R4", model_y(-32768, -32768, -32768), mx);
    end

    // R7: bubbles do not shift history
    do_reset();
    coef_a = 16'sd2; coef_b = 16'sd11; coef_c = -16'sd13;
    cur_req = "R7";
    cycle(1, 16'sd50, 1);
    for (int i = 0; i < 3; i++) cycle(0, 16'sd999, 1);
    cycle(1, 16'sd60, 1);
    cycle(0, -16'sd777, 1);
    cycle(1, 16'sd70, 1);
    drain();

    // R6: stall holds output and refuses input
    cur_req = "R6";
    cycle(1, 16'sd5, 1);
    cycle(1, 16'sd6, 1);
    cycle(1, 16'sd7, 1);
    for (int i = 0; i < 4; i++) cycle(1, 16'sd1234, 0);
    check(!in_ready, "R6", in_ready, 0);
    drain();

    // R8: reset mid-stream clears history
    cycle(1, 16'sd300, 1);
    cycle(1, 16'sd400, 0);
    do_reset();
    cur_req = "R8";
    cycle(1, 16'sd21, 1);
    drain();

    // R1: constrained random with back-pressure
    coef_a = 16'(signed'($urandom)); coef_b = 16'(signed'($urandom)); coef_c = 16'(signed'($urandom));
    do_reset();
    cur_req = "R1";
    for (int i = 0; i < 3000; i++) begin
      logic signed [W-1:0] d;
      case ($urandom_range(0, 7))
        0:       d = -16'sd32768;
        1:       d = 16'sd32767;
        default: d = 16'(signed'($urandom));
      endcase
      cycle($urandom_range(0, 3) != 0, d, $urandom_range(0, 3) != 0);
    end
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule